// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Clock Generator

This block is a two-wire serial bus slave that holds six configuration bytes of a system clock generator. It watches the bus clock and data lines and drives only an open-drain pull-down on the data line. The bus lines reach the block unsynchronized. Two flops per line bring them into the system clock domain. From there the block finds clock edges and START and STOP conditions.

A write transfer has no register pointer. The master sends the device address, then two bytes (a command code and a byte count). The slave acknowledges both and throws them away. Every byte after those two lands in the next register, starting at register 0. A read transfer returns a fixed byte count first, then the registers from register 0 upward. Register 0 carries the spread-spectrum controls, a frequency-select code with its override flag, and an all-outputs tristate flag. Registers 1 to 5 are output enable masks. The block decodes these fields and presents them on ports for the clock synthesis logic.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The slave acknowledges the address byte D2h (write) and D3h (read), which is 7-bit address 69h with the read flag in bit 0. Any other address is not acknowledged, and the bytes that follow it are not acknowledged and change nothing.
- R2: Each byte the slave accepts is acknowledged by pulling the data line low for the whole ninth clock high phase.
- R3: In a write, the first two bytes after the address are acknowledged and change no register.
- R4: Write data bytes are stored in registers 0, 1, 2 and so on, in order. Zero data bytes is allowed and leaves every register unchanged.
- R5: Write data bytes beyond register 5 are acknowledged and have no effect.
- R6: A read first returns 06h (the register count), then register 0 upward. Positions beyond register 5 return FFh. A master NACK ends the slave's driving.
- R7: Register 0 decodes as follows: bit 7 selects the wide spread depth, bits 6:4 hold the frequency code, bit 3 makes that code override the strap pins, bit 2 selects down spread (0 is centre), bit 1 enables spreading, and bit 0 tristates all outputs. It resets to 00h.
- R8: Registers 1 to 5 reset to FFh and appear on `out_en`, with register k in bits 8k-1 to 8k-8. Reserved bits always read and drive as 1. The reserved bits are: register 1 bits 7:4, register 2 bit 7, register 4 bits 7:4, and register 5 bits 7:5 and 3:2.
- R9: A START at any point restarts the address phase. A STOP at any point returns the slave to idle with the data line released. Bytes clocked without a preceding START are not acknowledged.
- R10: The slave changes its data-line pull only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls the data line low |
| ss_wide | output | 1 | Wide spread depth selected |
| fsel_code | output | 3 | Frequency select code |
| fsel_sw | output | 1 | Code overrides the strap pins |
| ss_down | output | 1 | Down spread (0 is centre spread) |
| ss_on | output | 1 | Spread spectrum enabled |
| outs_tristate | output | 1 | Tristate all clock outputs |
| out_en | output | 40 | Output enable masks from registers 1 to 5 |

## Verification
The assertions assume the bus clock holds each level for several system cycles. They also assume the master changes the data line only while the clock is low, except for a deliberate START or STOP. With those assumptions, a START or STOP is never detected in the same cycle as a clock edge. The bench master holds each bus clock phase for eight system cycles. It waits two cycles after each falling edge before it moves the data line. It never issues a START or STOP while the slave is pulling the line. The random transfers keep to legal frames. Directed cases cover a wrong address, an abort in the middle of a byte, and bytes clocked after a STOP.

// File: rtl/clkcfg_pkg.sv
// Shared constants and types for the serial configuration slave.
// Assumes six register bytes; the reserved-bit layout follows the
// fixed field positions the clock synthesis logic decodes.
package clkcfg_pkg;

    localparam int NUM_REGS = 6;
    localparam int IDX_W    = 4;
    localparam int SYNC_STAGES = 2;
    localparam logic [6:0] DEV_ADDR = 7'h69;

    // Reserved bits per register, register 5 in the top byte.
    localparam logic [NUM_REGS*8-1:0] RSV_MASK =
        {8'hEC, 8'hF0, 8'h00, 8'h80, 8'hF0, 8'h00};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } bus_state_t;

endpackage

// File: rtl/clkcfg_line_sync.sv
// Brings the bus clock and data lines into the system clock domain and
// derives edge and START/STOP strobes. Assumes the system clock is at
// least eight times the bus clock. Strobes are one system cycle wide.
module clkcfg_line_sync #(
    parameter int STAGES = clkcfg_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Synchronizer chains and previous-level history, idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    // Edge and bus-condition decode from current and previous levels.
    always_comb begin
        scl_lvl  = scl_pipe[STAGES-1];
        sda_lvl  = sda_pipe[STAGES-1];
        scl_rise = scl_lvl & ~scl_prev;
        scl_fall = ~scl_lvl & scl_prev;
        start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/clkcfg_regfile.sv
// Holds the configuration bytes. Writes force reserved bits to 1.
// Reads of an index beyond the last register return FFh.
// Assumes at most one write per cycle from the bus controller.
module clkcfg_regfile #(
    parameter int NUM_REGS = clkcfg_pkg::NUM_REGS,
    parameter int IDX_W    = clkcfg_pkg::IDX_W,
    parameter logic [NUM_REGS*8-1:0] RSV = clkcfg_pkg::RSV_MASK
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] reg_flat
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam logic [7:0] RST_VAL = (g == 0) ? 8'h00 : 8'hFF;
            // One register byte: reset value, else load on matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    reg_flat[g*8 +: 8] <= RST_VAL;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    reg_flat[g*8 +: 8] <= wr_data | RSV[g*8 +: 8];
                end
            end
        end
    endgenerate

    // Read multiplexer with FFh for out-of-range indices.
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = reg_flat[i*8 +: 8];
            end
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx <= LAST_IDX)); // R5

    AST_CFG0_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (reg_flat[7:0] == 8'h00)); // R7

    AST_RSV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == LAST_IDX) |-> ((rd_data & RSV[NUM_REGS*8-1 -: 8]) == RSV[NUM_REGS*8-1 -: 8])); // R8

endmodule

// File: rtl/clkcfg_bus_fsm.sv
// Byte-level protocol engine for the serial slave: address match,
// two discarded leading write bytes, sequential data writes, and a
// count-first sequential read. A START restarts and a STOP idles it from
// any state. Assumes synchronized lines and single-cycle edge strobes.
module clkcfg_bus_fsm #(
    parameter int NUM_REGS = clkcfg_pkg::NUM_REGS,
    parameter int IDX_W    = clkcfg_pkg::IDX_W,
    parameter logic [6:0] DEV_ADDR = clkcfg_pkg::DEV_ADDR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic [7:0]       rd_data,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sda_pull
);

    import clkcfg_pkg::*;

    localparam int          SKIP_BYTES = 2;
    localparam logic [IDX_W-1:0] DATA_FIRST = IDX_W'(SKIP_BYTES);
    localparam logic [IDX_W-1:0] DATA_END   = IDX_W'(SKIP_BYTES + NUM_REGS);
    localparam logic [7:0]  COUNT_BYTE = 8'(NUM_REGS);

    bus_state_t       state;
    logic [3:0]       bitcnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic             is_addr;
    logic             rw_rd;
    logic             nack;
    logic [IDX_W-1:0] byte_idx;
    logic [IDX_W-1:0] idx_next;
    logic [7:0]       load_byte;

    // Saturating byte position and the next byte to transmit.
    always_comb begin
        idx_next  = (byte_idx == '1) ? byte_idx : byte_idx + 1'b1;
        rd_idx    = byte_idx - 1'b1;
        load_byte = (byte_idx == '0) ? COUNT_BYTE : rd_data;
    end

    // Protocol state machine; START and STOP take priority over edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            rx_sh    <= '0;
            tx_sh    <= 8'hFF;
            is_addr  <= 1'b0;
            rw_rd    <= 1'b0;
            nack     <= 1'b0;
            byte_idx <= '0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                state    <= ST_RX;
                bitcnt   <= '0;
                is_addr  <= 1'b1;
                rw_rd    <= 1'b0;
                byte_idx <= '0;
            end else if (stop_ev) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh  <= {rx_sh[6:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (is_addr) begin
                                is_addr <= 1'b0;
                                if (rx_sh[7:1] == DEV_ADDR) begin
                                    rw_rd <= rx_sh[0];
                                    state <= ST_RX_ACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else begin
                                state    <= ST_RX_ACK;
                                byte_idx <= idx_next;
                                if (byte_idx >= DATA_FIRST && byte_idx < DATA_END) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= byte_idx - DATA_FIRST;
                                    wr_data <= rx_sh;
                                end
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw_rd) begin
                                state    <= ST_TX;
                                tx_sh    <= load_byte;
                                byte_idx <= idx_next;
                            end else begin
                                state <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                state <= ST_TX_ACK;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b1};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            nack <= sda_lvl;
                        end else if (scl_fall) begin
                            if (nack) begin
                                state <= ST_SKIP;
                            end else begin
                                state    <= ST_TX;
                                tx_sh    <= load_byte;
                                byte_idx <= idx_next;
                                bitcnt   <= '0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Open-drain pull: acknowledge slot, or a zero data bit while sending.
    always_comb begin
        sda_pull = (state == ST_RX_ACK) || (state == ST_TX && !tx_sh[7]);
    end

    AST_PULL_CHANGES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && !start_ev && !stop_ev) |=> $stable(sda_pull)); // R10

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE) && !sda_pull); // R9

    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_RX) && is_addr && (bitcnt == 4'd0)); // R9

    AST_NO_WRITE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rw_rd); // R4

    AST_ACK_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_pull); // R1

endmodule

// File: rtl/clkcfg_i2c_slave.sv
// Top of the serial configuration slave: line synchronizer, protocol
// engine and register bytes, plus field decode of the stored bytes.
// Assumes an external pull-up on the data line and a system clock at
// least eight times the bus clock.
module clkcfg_i2c_slave #(
    parameter int NUM_REGS = clkcfg_pkg::NUM_REGS,
    parameter int IDX_W    = clkcfg_pkg::IDX_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_in,
    input  logic                      sda_in,
    output logic                      sda_pull,
    output logic                      ss_wide,
    output logic [2:0]                fsel_code,
    output logic                      fsel_sw,
    output logic                      ss_down,
    output logic                      ss_on,
    output logic                      outs_tristate,
    output logic [(NUM_REGS-1)*8-1:0] out_en
);

    logic             scl_lvl;
    logic             sda_lvl;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_ev;
    logic             stop_ev;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    logic [NUM_REGS*8-1:0] reg_flat;

    clkcfg_line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    clkcfg_bus_fsm #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .sda_pull (sda_pull)
    );

    clkcfg_regfile #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .reg_flat (reg_flat)
    );

    // Field decode of register 0 and the enable masks of the rest.
    always_comb begin
        ss_wide       = reg_flat[7];
        fsel_code     = reg_flat[6:4];
        fsel_sw       = reg_flat[3];
        ss_down       = reg_flat[2];
        ss_on         = reg_flat[1];
        outs_tristate = reg_flat[0];
        out_en        = reg_flat[NUM_REGS*8-1:8];
    end

endmodule

// File: tb/tb_clkcfg_i2c_slave.sv
module tb_clkcfg_i2c_slave;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_pull;
    logic ss_wide, fsel_sw, ss_down, ss_on, outs_tristate;
    logic [2:0] fsel_code;
    logic [39:0] out_en;
    wire sda_line = sda_drv & ~sda_pull;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [7:0] model [0:5];
    logic [7:0] wbuf [0:15];

    always #2 clk = ~clk;

    clkcfg_i2c_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
        .sda_pull(sda_pull), .ss_wide(ss_wide), .fsel_code(fsel_code),
        .fsel_sw(fsel_sw), .ss_down(ss_down), .ss_on(ss_on),
        .outs_tristate(outs_tristate), .out_en(out_en)
    );

    function automatic logic [7:0] rsv(int i);
        case (i)
            1: return 8'hF0;
            2: return 8'h80;
            4: return 8'hF0;
            5: return 8'hEC;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(int pos);
        if (pos == 0) return 8'h06;
        if (pos <= 6) return model[pos-1];
        return 8'hFF;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        w(2); sda_drv = 1'b1; w(Q-2); scl_drv = 1'b1; w(Q);
        sda_drv = 1'b0; w(Q); scl_drv = 1'b0;
    endtask

    task automatic bus_stop();
        w(2); sda_drv = 1'b0; w(Q-2); scl_drv = 1'b1; w(Q);
        sda_drv = 1'b1; w(Q);
    endtask

    task automatic put_bit(logic b);
        w(2); sda_drv = b; w(Q-2); scl_drv = 1'b1; w(Q); scl_drv = 1'b0;
    endtask

    task automatic put_byte(logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        w(2); sda_drv = 1'b1; w(Q-2); scl_drv = 1'b1; w(Q/2);
        ack = sda_line; w(Q/2); scl_drv = 1'b0;
    endtask

    task automatic get_byte(logic master_nack, output logic [7:0] b);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) begin
            w(Q); scl_drv = 1'b1; w(Q/2); a1 = sda_line; w(Q/2); a2 = sda_line;
            chk("R10 data held while clock high", a2, a1);
            b[i] = a1; scl_drv = 1'b0;
        end
        w(2); sda_drv = master_nack; w(Q-2); scl_drv = 1'b1; w(Q);
        scl_drv = 1'b0; w(2); sda_drv = 1'b1;
    endtask

    task automatic chk_fields();
        logic [39:0] e;
        for (int k = 1; k <= 5; k++) e[(k-1)*8 +: 8] = model[k];
        chk("R7 byte0 fields", {ss_wide, fsel_code, fsel_sw, ss_down, ss_on, outs_tristate}, model[0]);
        chk("R8 enable masks", out_en, e);
    endtask

    task automatic wr_txn(int n, logic [7:0] cmd, logic [7:0] cnt);
        logic ack;
        bus_start();
        put_byte(8'hD2, ack); chk("R1 write address ack", ack, 1'b0);
        put_byte(cmd, ack);   chk("R3 command byte ack", ack, 1'b0);
        put_byte(cnt, ack);   chk("R3 count byte ack", ack, 1'b0);
        for (int k = 0; k < n; k++) begin
            put_byte(wbuf[k], ack);
            if (k < 6) begin
                chk("R2 data byte ack", ack, 1'b0);
                model[k] = wbuf[k] | rsv(k);
            end else begin
                chk("R5 extra byte ack", ack, 1'b0);
            end
        end
        bus_stop();
        chk_fields();
    endtask

    task automatic rd_txn(int k);
        logic ack;
        logic [7:0] b;
        bus_start();
        put_byte(8'hD3, ack); chk("R1 read address ack", ack, 1'b0);
        get_byte(k == 0, b);  chk("R6 count byte", b, 8'h06);
        for (int j = 1; j <= k; j++) begin
            get_byte(j == k, b);
            chk("R6 R8 read byte", b, exp_read(j));
        end
        bus_stop();
        chk("R6 line released after NACK", sda_pull, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        int seed;
        seed = $urandom(32'h5EED);
        model[0] = 8'h00;
        for (int i = 1; i < 6; i++) model[i] = 8'hFF;
        w(5); rst_n = 1'b1; w(5);

        chk("R9 idle after reset", sda_pull, 1'b0);
        chk_fields();                                   // R7 R8 reset values

        // Full write with reserved bits cleared in data
        for (int i = 0; i < 6; i++) wbuf[i] = 8'h00;
        wbuf[0] = 8'hA6;
        wr_txn(6, 8'h55, 8'hAA);                        // R3 R4 R8
        rd_txn(7);                                      // R6 beyond range

        // More bytes than registers
        for (int i = 0; i < 9; i++) wbuf[i] = 8'(8'h31 * (i + 1));
        wr_txn(9, 8'h00, 8'h09);                        // R5
        rd_txn(8);

        // Zero data bytes
        wr_txn(0, 8'hFF, 8'hFF);                        // R4

        // Wrong address: not acknowledged, nothing changes
        bus_start();
        put_byte(8'hA4, ack); chk("R1 foreign address nack", ack, 1'b1);
        put_byte(8'h00, ack); chk("R1 ignored byte nack", ack, 1'b1);
        bus_stop();
        chk_fields();

        // Byte clocked after STOP without START
        put_byte(8'hD2, ack); chk("R9 no ack without start", ack, 1'b1);

        // Abort mid-byte with a repeated START
        bus_start();
        put_byte(8'hD2, ack); put_byte(8'h00, ack); put_byte(8'h00, ack);
        put_byte(8'h11, ack); model[0] = 8'h11;
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        wbuf[0] = 8'h3C;
        wr_txn(1, 8'h12, 8'h34);                        // R9
        rd_txn(2);

        // Random mix of writes and reads
        for (int t = 0; t < 24; t++) begin
            if ($urandom_range(1, 0) == 1) begin
                int n;
                n = $urandom_range(8, 0);
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
                wr_txn(n, 8'($urandom), 8'($urandom));
            end else begin
                rd_txn($urandom_range(8, 0));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule